// File: doc/BRIEF.md
# Free-Running Tick Counter with Low-Word Compare Interrupt

This block is a system timer peripheral that sits on a simple word-wide register bus. It holds a tick counter twice the bus width. The counter advances by one on every clock cycle in which a prescaled tick-enable input is high. Software reads the counter as two separate words, low and high. The hardware does not latch one word while the other is read. Software reads high, then low, then high again, and repeats the sequence if the two high reads differ.

A single compare register is checked against the low word only. A compare is armed by setting an enable bit in the control/status word. The low word then advances onto the compare value. At that point a sticky match flag sets. A level interrupt is asserted while the flag and the enable bit are both set. Software writes a one to the flag bit to clear it.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset, the counter words, the compare register, the enable bit, the match flag and `irq` are all zero.
- R2: The counter adds one on each clock edge where `tick_en` is high and holds otherwise. When the low word passes from all ones to zero, the high word adds one on the same edge. The low word reads at offset 0x4 and the high word at offset 0x8.
- R3: Reading either counter word has no side effect. Writes to offsets 0x4 and 0x8 are ignored.
- R4: The compare register at offset 0xC is writable and readable across the full word width.
- R5: The control/status word sits at offset 0x0. Bit 0 is the match flag and bit 4 is the compare enable, which is written directly from bit 4. All other bits read zero.
- R6: The match flag sets on the clock edge where a tick moves the low word to a value equal to the compare register, provided the enable bit was set before that edge. With the enable bit clear, no flag is set.
- R7: A match fires only when a tick moves the low word onto the compare value. A low word that stays equal to the compare value while ticks stall does not set the flag again. Writing a compare value equal to the current low word does not set it either. Otherwise the flag holds.
- R8: Writing control/status with bit 0 set clears the flag. Writing with bit 0 clear leaves the flag unchanged.
- R9: If a flag-clearing write and a new match fall on the same edge, the flag stays set.
- R10: `irq` is high exactly while both the flag and the enable bit are set. Clearing the enable bit lowers `irq` and keeps the flag.
- R11: Offsets other than 0x0, 0x4, 0x8 and 0xC read zero, and writes to them change no state.
- R12: A compare value reached through a wrap of the low word produces exactly one match. This covers a delta of all ones, one tick short of a full turn. A delta as small as 6 ticks also produces a correct match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled tick; counter advances on edges where it is high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data; combinational from the offset while a read is strobed, zero otherwise |
| irq | output | 1 | Level interrupt, flag AND enable |

## Verification
The bench builds the timer with `WORD_W = 8` and `ADDR_W = 4`. The counter is then 16 bits wide. A low-word wrap, the carry into the high word and a compare delta of all ones (255 ticks) all fit in a few hundred cycles. This makes the wrap-through match and the carry directly observable at the ports. The default 32-bit word keeps the same bit positions and offsets, so bits 0 and 4 of control/status keep their meaning. `WORD_W` must be at least 8.

// File: rtl/tct_pkg.sv
package tct_pkg;

    // Register offsets (byte addresses, word spaced)
    localparam int OFF_CTRL   = 'h0;
    localparam int OFF_CNT_LO = 'h4;
    localparam int OFF_CNT_HI = 'h8;
    localparam int OFF_CMP    = 'hC;

    // Control/status bit positions
    localparam int FLAG_POS = 0;
    localparam int EN_POS   = 4;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CTRL,
        RSEL_LO,
        RSEL_HI,
        RSEL_CMP
    } rsel_e;

    function automatic rsel_e decode_offset(input logic [31:0] off);
        rsel_e r;
        case (off)
            OFF_CTRL:   r = RSEL_CTRL;
            OFF_CNT_LO: r = RSEL_LO;
            OFF_CNT_HI: r = RSEL_HI;
            OFF_CMP:    r = RSEL_CMP;
            default:    r = RSEL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [WORD_W-1:0] cnt_lo,
    output logic [WORD_W-1:0] cnt_hi,
    output logic [WORD_W-1:0] lo_next,
    output logic              step
);
    localparam int CNT_W = 2 * WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic carry;

    always_comb begin
        cnt_d = cnt_q;
        carry = &cnt_q.lo;
        if (tick_en) begin
            cnt_d.lo = cnt_q.lo + WORD_W'(1);
            cnt_d.hi = cnt_q.hi + WORD_W'(carry);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_lo  = cnt_q.lo;
    assign cnt_hi  = cnt_q.hi;
    assign lo_next = cnt_d.lo;
    assign step    = tick_en;

    // R2: one tick adds exactly one to the whole count
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + CNT_W'(1)));

    // R2: no tick, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable({cnt_hi, cnt_lo}));

    // R2: low-word wrap carries into the high word
    p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (&cnt_lo)) |=> (cnt_lo == '0 && cnt_hi == $past(cnt_hi) + WORD_W'(1)));

endmodule

// File: rtl/tct_compare.sv
module tct_compare
    import tct_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [WORD_W-1:0] lo_next,
    input  logic              wr_ctrl,
    input  logic              wr_cmp,
    input  logic [WORD_W-1:0] wdata,
    output logic              flag,
    output logic              en,
    output logic [WORD_W-1:0] cmp,
    output logic              irq
);
    typedef struct packed {
        logic [WORD_W-1:0] cmp;
        logic              en;
        logic              flag;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic match_evt;
    logic clr_req;

    always_comb begin
        st_d      = st_q;
        match_evt = step && st_q.en && (lo_next == st_q.cmp);
        clr_req   = wr_ctrl && wdata[FLAG_POS];
        if (wr_cmp)  st_d.cmp = wdata;
        if (wr_ctrl) st_d.en  = wdata[EN_POS];
        if (match_evt)    st_d.flag = 1'b1;
        else if (clr_req) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign en   = st_q.en;
    assign cmp  = st_q.cmp;
    assign irq  = st_q.flag & st_q.en;

    // R6: an armed tick landing on the compare value sets the flag
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && en && lo_next == cmp) |=> flag);

    // R7: without a match or a clear the flag holds
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_evt && !clr_req) |=> (flag == $past(flag)));

    // R8: write-one clears when no match collides
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !match_evt) |=> !flag);

    // R9: match beats a simultaneous clear
    p_match_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && match_evt) |=> flag);

    // R10: dropping the enable lowers the interrupt
    p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[EN_POS]) |=> !irq);

    // R4: compare write loads the full word
    p_cmp_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp |=> (cmp == $past(wdata)));

endmodule

// File: rtl/tct_regs.sv
module tct_regs
    import tct_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] cnt_lo,
    input  logic [WORD_W-1:0] cnt_hi,
    input  logic [WORD_W-1:0] cmp_val,
    output logic              wr_ctrl,
    output logic              wr_cmp,
    output logic [WORD_W-1:0] rdata
);
    typedef struct packed {
        logic              wr_ctrl;
        logic              wr_cmp;
        logic [WORD_W-1:0] rdata;
    } dec_t;

    rsel_e rsel;
    dec_t  dec;

    always_comb begin
        rsel        = decode_offset(32'(bus_addr));
        dec         = '0;
        dec.wr_ctrl = bus_sel && bus_wr && (rsel == RSEL_CTRL);
        dec.wr_cmp  = bus_sel && bus_wr && (rsel == RSEL_CMP);
        if (bus_sel && !bus_wr) begin
            case (rsel)
                RSEL_CTRL: dec.rdata = ctrl_word;
                RSEL_LO:   dec.rdata = cnt_lo;
                RSEL_HI:   dec.rdata = cnt_hi;
                RSEL_CMP:  dec.rdata = cmp_val;
                default:   dec.rdata = '0;
            endcase
        end
    end

    assign wr_ctrl = dec.wr_ctrl;
    assign wr_cmp  = dec.wr_cmp;
    assign rdata   = dec.rdata;

    // R11: unmapped offsets read zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && rsel == RSEL_NONE) |-> (rdata == '0));

    // R3, R11: no write strobe leaves for counter or unmapped offsets
    p_no_stray_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && rsel != RSEL_CTRL && rsel != RSEL_CMP) |-> (!wr_ctrl && !wr_cmp));

endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
    import tct_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    logic [WORD_W-1:0] cnt_lo, cnt_hi, lo_next, cmp_val, ctrl_word;
    logic              step, wr_ctrl, wr_cmp, flag, en;

    tct_counter #(.WORD_W(WORD_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi),
        .lo_next (lo_next),
        .step    (step)
    );

    tct_compare #(.WORD_W(WORD_W)) u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .lo_next (lo_next),
        .wr_ctrl (wr_ctrl),
        .wr_cmp  (wr_cmp),
        .wdata   (bus_wdata),
        .flag    (flag),
        .en      (en),
        .cmp     (cmp_val),
        .irq     (irq)
    );

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[FLAG_POS] = flag;
        ctrl_word[EN_POS]   = en;
    end

    tct_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .ctrl_word (ctrl_word),
        .cnt_lo    (cnt_lo),
        .cnt_hi    (cnt_hi),
        .cmp_val   (cmp_val),
        .wr_ctrl   (wr_ctrl),
        .wr_cmp    (wr_cmp),
        .rdata     (bus_rdata)
    );

    // R10: interrupt follows flag and enable, checked at the ports over time
    p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_ctrl && !step) |=> irq);

endmodule

// File: tb/tick_compare_timer_bench.sv
`timescale 1ns/1ps
module tick_compare_timer_bench;
    localparam int WORD_W = 8;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [WORD_W-1:0] bus_wdata = '0;
    logic [WORD_W-1:0] bus_rdata;
    logic              irq;

    always #10 clk = ~clk;

    tick_compare_timer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_tick_compare_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct {
        bit                is_irq;
        logic [WORD_W-1:0] exp;
        string             tag;
    } item_t;

    item_t sb[$];
    logic  mon_go = 1'b0;
    int    n_checks = 0;
    int    n_fail = 0;

    // Monitor: pops one expected item per strobed sample, mid-cycle
    always @(negedge clk) begin
        if (mon_go) begin
            item_t it;
            logic [WORD_W-1:0] act;
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty (no requirement) actual=%0h expected=item", bus_rdata);
            end else begin
                it  = sb.pop_front();
                act = it.is_irq ? WORD_W'(irq) : bus_rdata;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
        cyc();
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] e, input string t);
        cyc();
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        sb.push_back('{is_irq: 1'b0, exp: e, tag: t});
        mon_go = 1'b1;
        cyc();
        bus_sel = 1'b0; mon_go = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        cyc();
        sb.push_back('{is_irq: 1'b1, exp: WORD_W'(e), tag: t});
        mon_go = 1'b1;
        cyc();
        mon_go = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc();
            tick_en = 1'b1;
        end
        cyc();
        tick_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, 8'h00, "R1 ctrl after reset");
        rd(4'h4, 8'h00, "R1 low word after reset");
        rd(4'h8, 8'h00, "R1 high word after reset");
        rd(4'hC, 8'h00, "R1 compare after reset");
        chk_irq(1'b0, "R1 irq after reset");

        // R2 counting, R3 side-effect free reads
        ticks(5);
        rd(4'h4, 8'h05, "R2 low word after 5 ticks");
        rd(4'h4, 8'h05, "R3 low word re-read");
        rd(4'h8, 8'h00, "R2 high word no carry");
        wr(4'h4, 8'hAA);
        wr(4'h8, 8'h55);
        rd(4'h4, 8'h05, "R3 low word write ignored");
        rd(4'h8, 8'h00, "R3 high word write ignored");

        // R4 compare register, R5 control layout
        wr(4'hC, 8'h3C);
        rd(4'hC, 8'h3C, "R4 compare readback");
        wr(4'h0, 8'hFF);
        rd(4'h0, 8'h10, "R5 only enable bit 4 reads back");

        // R6/R12 small delta of 6 ticks: count 5 -> 11
        wr(4'hC, 8'h0B);
        ticks(5);
        rd(4'h0, 8'h10, "R6 no flag before equality");
        chk_irq(1'b0, "R10 irq low before match");
        ticks(1);
        rd(4'h0, 8'h11, "R12 flag after 6-tick delta");
        chk_irq(1'b1, "R10 irq high on match");

        // R8 write-one-to-clear
        wr(4'h0, 8'h10);
        rd(4'h0, 8'h11, "R8 writing 0 keeps flag");
        wr(4'h0, 8'h11);
        rd(4'h0, 8'h10, "R8 writing 1 clears flag");
        chk_irq(1'b0, "R8 irq low after clear");

        // R7 stalled equality and equal compare write do not re-fire
        repeat (4) cyc();
        rd(4'h0, 8'h10, "R7 stalled equality no refire");
        wr(4'hC, 8'h0B);
        rd(4'h0, 8'h10, "R7 compare equal to count no match");

        // R6 disabled compare does not set flag
        wr(4'h0, 8'h00);
        wr(4'hC, 8'h0D);
        ticks(2);
        rd(4'h0, 8'h00, "R6 no flag while disabled");

        // R10 enable gating keeps the flag
        wr(4'h0, 8'h10);
        wr(4'hC, 8'h0F);
        ticks(2);
        rd(4'h0, 8'h11, "R6 flag when enabled");
        wr(4'h0, 8'h00);
        rd(4'h0, 8'h01, "R10 flag kept when enable cleared");
        chk_irq(1'b0, "R10 irq low with enable clear");
        wr(4'h0, 8'h11);
        rd(4'h0, 8'h10, "R8 clear with enable set");

        // R9 clear and match on the same edge: count 15 -> 16
        wr(4'hC, 8'h10);
        cyc();
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 8'h11;
        cyc();
        tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(4'h0, 8'h11, "R9 match wins over clear");
        wr(4'h0, 8'h11);
        rd(4'h0, 8'h10, "R9 later clear works");

        // R12 full-range delta through wrap: count 16, compare 15
        wr(4'hC, 8'h0F);
        ticks(254);
        rd(4'h0, 8'h10, "R12 no early match across wrap");
        rd(4'h4, 8'h0E, "R2 low word after wrap");
        rd(4'h8, 8'h01, "R2 carry into high word");
        ticks(1);
        rd(4'h0, 8'h11, "R12 single match after wrap");
        chk_irq(1'b1, "R12 irq after wrap match");

        // R11 unmapped offsets
        wr(4'h0, 8'h11);
        wr(4'h1, 8'hFF);
        wr(4'hD, 8'h77);
        wr(4'h7, 8'hFF);
        rd(4'h1, 8'h00, "R11 offset 0x1 reads zero");
        rd(4'hD, 8'h00, "R11 offset 0xD reads zero");
        rd(4'h6, 8'h00, "R11 offset 0x6 reads zero");
        rd(4'hC, 8'h0F, "R11 compare untouched");
        rd(4'h0, 8'h10, "R11 control untouched");
        rd(4'h4, 8'h0F, "R11 low word untouched");
        rd(4'h8, 8'h01, "R11 high word untouched");

        cyc();
        summary();
        $finish;
    end

endmodule